// File: doc/BRIEF.md
# Scatter-Gather Page-Table Entry Cache

This block sits between a DMA address translator and memory and keeps recently used scatter-gather page-table entries (PTEs) close at hand. The translator presents a bus page number. When the entry is cached, the block returns the 64-bit PTE one cycle after it accepts the lookup. On a miss it holds the lookup off and fetches the whole aligned group of four consecutive PTEs that contains the entry. It installs the group into one of eight lines and then serves the lookup from the cache.

Software keeps the cache coherent with the page table through two write-only invalidate registers. A write to the invalidate-all register drops every cached group, whatever value is written. A write to the selective register drops only the groups whose bus-address bits 31:16 equal the written tag. The tag travels pre-shifted, so it occupies write-data bits 19:4. Software uses the selective form when a range stays inside one 64 KB region and the full flush otherwise. A read of either register returns zero. The read completes only after every earlier invalidation has taken effect, which gives software an ordering point.

Top module: `sg_pte_cache`

## Requirements
- R1: After reset no entry is cached: lkReady, respValid, memReqValid and csrRdValid are low, and the first lookup misses and causes a fetch.
- R2: A lookup is accepted in a cycle where lkValid and lkReady are both high. respValid is high in the next cycle, together with the PTE for the looked-up page. The page number is bus-address bits 31:13, and its low two bits select the word within the group.
- R3: On a miss, lkReady stays low and one fetch is issued for group number = bus-address bits 31:15. memReqGroup is held stable while memReqValid waits for memReqReady. The four returned PTEs are taken with word k at memRespData bits 64k+63:64k. All four words then hit without a further fetch.
- R4: A write with csrSel=0 (invalidate-all) clears every cached group regardless of the tag value written, and the next lookup of any earlier group refetches.
- R5: A write with csrSel=1 (selective) carries the tag as write-data bits 19:4 on csrWrTag. Only groups whose bus-address bits 31:16 equal that tag are cleared, and groups with other tags keep hitting with their old data.
- R6: The cache has 8 lines. A fill goes to the lowest-numbered empty line. When no line is empty, it goes to the line chosen by a 7-bit binary-tree pseudo-LRU, which every hit and every fill updates to point away from the line used.
- R7: If an invalidation whose match covers the outstanding fill's group takes effect before or in the cycle the fill data returns, the data is discarded and the still-pending lookup fetches again. An invalidation that does not match lets the fill install normally.
- R8: A read of an invalidate register (csrRdEn) returns csrRdData = 0 with csrRdValid only after every earlier invalidate write has taken effect. No lookup is accepted while an invalidation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request, held until accepted |
| lkPage | input | 19 | Bus page number (bus-address bits 31:13) |
| lkReady | output | 1 | Lookup accepted this cycle (hit) |
| respValid | output | 1 | PTE response valid |
| respPte | output | 64 | Returned PTE |
| memReqValid | output | 1 | PTE group fetch request |
| memReqReady | input | 1 | Memory accepts the fetch |
| memReqGroup | output | 17 | Group number (bus-address bits 31:15) |
| memRespValid | input | 1 | Group data returning |
| memRespData | input | 256 | Four PTEs, word k at bits 64k+63:64k |
| csrWrEn | input | 1 | Invalidate register write strobe |
| csrRdEn | input | 1 | Invalidate register read strobe |
| csrSel | input | 1 | 0 = invalidate-all, 1 = selective |
| csrWrTag | input | 16 | Write-data bits 19:4 (tag of bus-address bits 31:16) |
| csrRdValid | output | 1 | Register read complete |
| csrRdData | output | 32 | Register read data (always zero) |

## Verification
The bench targets replacement after eight fills followed by a re-touch of the oldest group. A wrong tree update would evict the just-touched group, which shows up as an extra fetch. It issues selective invalidates against two groups sharing one 64 KB tag next to a third group with a different tag. A comparator on the wrong address bits would either keep stale data or throw away the neighbour, and the generation stamp in the returned PTE exposes either fault. It fires invalidates in the middle of an outstanding fill, both matching and non-matching. A design that installs a killed fill returns after a single fetch where two are expected, and a design that over-kills fetches twice where one is expected.

// File: rtl/sgpc_pkg.sv
package sgpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } fillState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic fillWrite;   // install the returning group into fillLine
    logic invalAll;    // clear every line
    logic invalByTag;  // clear lines whose region tag equals invalTag
    logic touchHit;    // lookup accepted: capture PTE, update recency
  } dpCtl_t;

endpackage

// File: rtl/sgpc_datapath.sv
module sgpc_datapath
  import sgpc_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int GROUP  = 4,
  parameter int LINES  = 8,
  parameter int GTAG_W = 17,
  parameter int ITAG_W = 16,
  parameter int ITAG_OFF = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtl_t                      ctl,
  input  logic [GTAG_W-1:0]           lkGroup,
  input  logic [$clog2(GROUP)-1:0]    lkWord,
  input  logic [$clog2(LINES)-1:0]    fillLine,
  input  logic [GTAG_W-1:0]           fillTag,
  input  logic [GROUP*PTE_W-1:0]      fillData,
  input  logic [ITAG_W-1:0]           invalTag,
  output logic                        hit,
  output logic [$clog2(LINES)-1:0]    victim,
  output logic [PTE_W-1:0]            respPte
);

  localparam int LINE_W = $clog2(LINES);
  localparam int TREE_W = LINES - 1;

  logic [LINES-1:0]      lineVld;
  logic [GTAG_W-1:0]     lineTag  [LINES];
  logic [PTE_W-1:0]      lineData [LINES][GROUP];
  logic [LINES-1:0]      hitVec;
  logic [LINES-1:0]      invalVec;
  logic [LINE_W-1:0]     hitLine;
  logic [TREE_W-1:0]     plruTree;
  logic                  anyFree;
  logic [LINE_W-1:0]     freeLine;

  // Walk the tree: a node bit of 1 steers toward the upper child.
  function automatic logic [LINE_W-1:0] plruPick(input logic [TREE_W-1:0] t);
    int node;
    node = 0;
    for (int d = 0; d < LINE_W; d++) begin
      node = 2 * node + 1 + int'(t[node]);
    end
    return LINE_W'(node - TREE_W);
  endfunction

  // Mark every node on the path to a used line as pointing away from it.
  function automatic logic [TREE_W-1:0] plruTouch(input logic [TREE_W-1:0] t,
                                                  input logic [LINE_W-1:0] l);
    logic [TREE_W-1:0] r;
    int node;
    r = t;
    node = 0;
    for (int d = 0; d < LINE_W; d++) begin
      r[node] = ~l[LINE_W-1-d];
      node = 2 * node + 1 + int'(l[LINE_W-1-d]);
    end
    return r;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : gLine
      assign hitVec[gi]   = lineVld[gi] && (lineTag[gi] == lkGroup);
      assign invalVec[gi] = ctl.invalAll ||
                            (ctl.invalByTag && (lineTag[gi][ITAG_OFF +: ITAG_W] == invalTag));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          lineVld[gi] <= 1'b0;
        end else if (ctl.fillWrite && (fillLine == LINE_W'(gi))) begin
          lineVld[gi] <= 1'b1;
        end else if (invalVec[gi]) begin
          lineVld[gi] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (ctl.fillWrite && (fillLine == LINE_W'(gi))) begin
          lineTag[gi] <= fillTag;
          for (int w = 0; w < GROUP; w++) begin
            lineData[gi][w] <= fillData[w*PTE_W +: PTE_W];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    hit     = |hitVec;
    hitLine = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hitVec[i]) hitLine = LINE_W'(i);
    end
  end

  always_comb begin
    anyFree  = ~&lineVld;
    freeLine = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!lineVld[i]) freeLine = LINE_W'(i);
    end
    victim = anyFree ? freeLine : plruPick(plruTree);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      plruTree <= '0;
    end else if (ctl.touchHit) begin
      plruTree <= plruTouch(plruTree, hitLine);
    end else if (ctl.fillWrite) begin
      plruTree <= plruTouch(plruTree, fillLine);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respPte <= '0;
    end else if (ctl.touchHit) begin
      respPte <= lineData[hitLine][lkWord];
    end
  end

endmodule

// File: rtl/sgpc_ctrl.sv
module sgpc_ctrl
  import sgpc_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int GTAG_W   = 17,
  parameter int ITAG_W   = 16,
  parameter int ITAG_OFF = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lkValid,
  input  logic [GTAG_W-1:0]         lkGroup,
  input  logic                      hit,
  input  logic [$clog2(LINES)-1:0]  victim,
  input  logic                      memReqReady,
  input  logic                      memRespValid,
  input  logic                      csrWrEn,
  input  logic                      csrRdEn,
  input  logic                      csrSel,
  input  logic [ITAG_W-1:0]         csrWrTag,
  output dpCtl_t                    ctl,
  output logic                      lkReady,
  output logic                      respValid,
  output logic                      memReqValid,
  output logic [GTAG_W-1:0]         fillTag,
  output logic [$clog2(LINES)-1:0]  fillLine,
  output logic [ITAG_W-1:0]         invalTag,
  output logic                      csrRdValid
);

  fillState_t state;
  logic       invalPend;
  logic       invalSelQ;
  logic       fillKill;
  logic       rdPend;
  logic       startFill;
  logic       fillMatch;

  always_comb begin
    lkReady   = (state == ST_IDLE) && !invalPend && hit;
    startFill = (state == ST_IDLE) && lkValid && !hit && !invalPend;
    fillMatch = invalPend && (!invalSelQ || (fillTag[ITAG_OFF +: ITAG_W] == invalTag));

    ctl            = '0;
    ctl.touchHit   = lkValid && lkReady;
    ctl.invalAll   = invalPend && !invalSelQ;
    ctl.invalByTag = invalPend && invalSelQ;
    ctl.fillWrite  = (state == ST_WAIT) && memRespValid && !fillKill && !fillMatch;

    memReqValid = (state == ST_REQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fillKill <= 1'b0;
      fillTag  <= '0;
      fillLine <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startFill) begin
            state    <= ST_REQ;
            fillTag  <= lkGroup;
            fillLine <= victim;
            fillKill <= 1'b0;
          end
        end
        ST_REQ: begin
          if (fillMatch) fillKill <= 1'b1;
          if (memReqReady) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (memRespValid) begin
            state    <= ST_IDLE;
            fillKill <= 1'b0;
          end else if (fillMatch) begin
            fillKill <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Invalidate writes take effect one cycle after acceptance.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      invalPend <= 1'b0;
      invalSelQ <= 1'b0;
      invalTag  <= '0;
    end else begin
      invalPend <= csrWrEn;
      if (csrWrEn) begin
        invalSelQ <= csrSel;
        invalTag  <= csrWrTag;
      end
    end
  end

  // A register read completes once no invalidation is left pending.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend     <= 1'b0;
      csrRdValid <= 1'b0;
      respValid  <= 1'b0;
    end else begin
      respValid  <= ctl.touchHit;
      csrRdValid <= 1'b0;
      if (csrRdEn) begin
        rdPend <= 1'b1;
      end else if (rdPend && !invalPend && !csrWrEn) begin
        rdPend     <= 1'b0;
        csrRdValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sg_pte_cache.sv
module sg_pte_cache
  import sgpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PTE_W      = 64,
  parameter int GROUP      = 4,
  parameter int LINES      = 8,
  parameter int TAG_LO     = 16,
  parameter int CSR_W      = 32
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         lkValid,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]                 lkPage,
  output logic                                         lkReady,
  output logic                                         respValid,
  output logic [PTE_W-1:0]                             respPte,
  output logic                                         memReqValid,
  input  logic                                         memReqReady,
  output logic [ADDR_W-PAGE_SHIFT-$clog2(GROUP)-1:0]   memReqGroup,
  input  logic                                         memRespValid,
  input  logic [GROUP*PTE_W-1:0]                       memRespData,
  input  logic                                         csrWrEn,
  input  logic                                         csrRdEn,
  input  logic                                         csrSel,
  input  logic [ADDR_W-TAG_LO-1:0]                     csrWrTag,
  output logic                                         csrRdValid,
  output logic [CSR_W-1:0]                             csrRdData
);

  localparam int GRP_W    = $clog2(GROUP);
  localparam int LINE_W   = $clog2(LINES);
  localparam int GTAG_W   = ADDR_W - PAGE_SHIFT - GRP_W;
  localparam int ITAG_W   = ADDR_W - TAG_LO;
  localparam int ITAG_OFF = TAG_LO - PAGE_SHIFT - GRP_W;

  dpCtl_t              ctl;
  logic                hit;
  logic [LINE_W-1:0]   victim;
  logic [LINE_W-1:0]   fillLine;
  logic [GTAG_W-1:0]   fillTag;
  logic [ITAG_W-1:0]   invalTag;
  logic [GTAG_W-1:0]   lkGroup;
  logic [GRP_W-1:0]    lkWord;

  assign lkGroup     = lkPage[ADDR_W-PAGE_SHIFT-1 -: GTAG_W];
  assign lkWord      = lkPage[GRP_W-1:0];
  assign memReqGroup = fillTag;
  assign csrRdData   = '0;

  sgpc_ctrl #(
    .LINES(LINES), .GTAG_W(GTAG_W), .ITAG_W(ITAG_W), .ITAG_OFF(ITAG_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkGroup(lkGroup), .hit(hit),
    .victim(victim), .memReqReady(memReqReady), .memRespValid(memRespValid),
    .csrWrEn(csrWrEn), .csrRdEn(csrRdEn), .csrSel(csrSel), .csrWrTag(csrWrTag),
    .ctl(ctl), .lkReady(lkReady), .respValid(respValid), .memReqValid(memReqValid),
    .fillTag(fillTag), .fillLine(fillLine), .invalTag(invalTag), .csrRdValid(csrRdValid)
  );

  sgpc_datapath #(
    .PTE_W(PTE_W), .GROUP(GROUP), .LINES(LINES), .GTAG_W(GTAG_W),
    .ITAG_W(ITAG_W), .ITAG_OFF(ITAG_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lkGroup(lkGroup), .lkWord(lkWord),
    .fillLine(fillLine), .fillTag(fillTag), .fillData(memRespData),
    .invalTag(invalTag), .hit(hit), .victim(victim), .respPte(respPte)
  );

endmodule

// File: rtl/sg_pte_cache_chk.sv
module sg_pte_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int GROUP      = 4
) (
  input logic                                       clk,
  input logic                                       rstN,
  input logic                                       lkValid,
  input logic                                       lkReady,
  input logic [ADDR_W-PAGE_SHIFT-1:0]               lkPage,
  input logic                                       respValid,
  input logic                                       memReqValid,
  input logic                                       memReqReady,
  input logic [ADDR_W-PAGE_SHIFT-$clog2(GROUP)-1:0] memReqGroup,
  input logic                                       csrWrEn
);

  localparam int GTAG_W = ADDR_W - PAGE_SHIFT - $clog2(GROUP);

  assert_resp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(lkValid && lkReady));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqGroup)));

  assert_fetch_after_miss_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(lkValid && !lkReady));

  assert_group_of_lookup_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && lkValid) |-> (memReqGroup == lkPage[ADDR_W-PAGE_SHIFT-1 -: GTAG_W]));

  assert_stall_during_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !lkReady);

  assert_block_after_inval_R8: assert property (@(posedge clk) disable iff (!rstN)
    csrWrEn |=> !lkReady);

endmodule

bind sg_pte_cache sg_pte_cache_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .GROUP(GROUP)
) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkReady(lkReady), .lkPage(lkPage),
  .respValid(respValid), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqGroup(memReqGroup), .csrWrEn(csrWrEn)
);

// File: tb/sg_pte_cache_bench.sv
module sg_pte_cache_bench;

  logic         clk = 1'b0;
  logic         rstN;
  logic         lkValid;
  logic [18:0]  lkPage;
  logic         lkReady;
  logic         respValid;
  logic [63:0]  respPte;
  logic         memReqValid;
  logic         memReqReady;
  logic [16:0]  memReqGroup;
  logic         memRespValid;
  logic [255:0] memRespData;
  logic         csrWrEn;
  logic         csrRdEn;
  logic         csrSel;
  logic [15:0]  csrWrTag;
  logic         csrRdValid;
  logic [31:0]  csrRdData;

  int          checks = 0;
  int          fails = 0;
  int          fetchCount = 0;
  int          reqStall = 1;
  int          respDelay = 2;
  logic [7:0]  memGen = 8'd0;
  logic [16:0] lastGroup = '0;
  logic [63:0] expQ[$];
  string       reqQ[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sg_pte_cache u_sg_pte_cache (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPage(lkPage), .lkReady(lkReady),
    .respValid(respValid), .respPte(respPte), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqGroup(memReqGroup), .memRespValid(memRespValid),
    .memRespData(memRespData), .csrWrEn(csrWrEn), .csrRdEn(csrRdEn), .csrSel(csrSel),
    .csrWrTag(csrWrTag), .csrRdValid(csrRdValid), .csrRdData(csrRdData)
  );

  function automatic logic [63:0] pteOf(input logic [18:0] idx, input logic [7:0] gen);
    return {gen, 8'h5A, 29'd0, idx};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: accepts a fetch after reqStall cycles, returns after respDelay.
  initial begin
    memReqReady  = 1'b0;
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        repeat (reqStall) @(negedge clk);
        memReqReady = 1'b1;
        lastGroup   = memReqGroup;
        @(negedge clk);
        memReqReady = 1'b0;
        fetchCount++;
        repeat (respDelay) @(negedge clk);
        for (int k = 0; k < 4; k++) memRespData[k*64 +: 64] = pteOf({lastGroup, 2'(k)}, memGen);
        memRespValid = 1'b1;
        @(negedge clk);
        memRespValid = 1'b0;
      end
    end
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected response", respPte, 64'd0);
      end else begin
        logic [63:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(respPte == e, r, respPte, e);
      end
    end
  end

  task automatic doLookup(input logic [16:0] grp, input logic [1:0] word, input logic [7:0] gen,
                          input int expFetch, input string req);
    int f0;
    f0 = fetchCount;
    expQ.push_back(pteOf({grp, word}, gen));
    reqQ.push_back(req);
    @(negedge clk);
    lkValid = 1'b1;
    lkPage  = {grp, word};
    #1;
    while (!lkReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    lkValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check((fetchCount - f0) == expFetch, {req, " fetch count"}, 64'(fetchCount - f0), 64'(expFetch));
  endtask

  task automatic csrWrite(input logic sel, input logic [15:0] tag);
    @(negedge clk);
    csrWrEn  = 1'b1;
    csrSel   = sel;
    csrWrTag = tag;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic csrRead(input string req);
    bit got;
    got = 1'b0;
    @(negedge clk);
    csrRdEn = 1'b1;
    @(negedge clk);
    csrRdEn = 1'b0;
    for (int i = 0; i < 20 && !got; i++) begin
      if (csrRdValid) begin
        got = 1'b1;
        check(csrRdData == 32'd0, {req, " read data"}, 64'(csrRdData), 64'd0);
      end else begin
        @(negedge clk);
      end
    end
    check(got, {req, " read completes"}, 64'(got), 64'd1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN     = 1'b0;
    lkValid  = 1'b0;
    lkPage   = '0;
    csrWrEn  = 1'b0;
    csrRdEn  = 1'b0;
    csrSel   = 1'b0;
    csrWrTag = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(!lkReady,     "R1 lkReady after reset",     64'(lkReady),     64'd0);
    check(!respValid,   "R1 respValid after reset",   64'(respValid),   64'd0);
    check(!memReqValid, "R1 memReqValid after reset", 64'(memReqValid), 64'd0);
    check(!csrRdValid,  "R1 csrRdValid after reset",  64'(csrRdValid),  64'd0);

    // R1/R3: first lookup misses, fetches its group
    doLookup(17'd3, 2'd2, 8'd0, 1, "R1 first lookup");
    check(lastGroup == 17'd3, "R3 fetched group", 64'(lastGroup), 64'd3);
    doLookup(17'd3, 2'd0, 8'd0, 0, "R3 group word 0 hit");
    doLookup(17'd3, 2'd3, 8'd0, 0, "R2 group word 3 hit");

    // R4: invalidate-all with an arbitrary value
    csrWrite(1'b0, 16'hBEEF);
    memGen = 8'd1;
    doLookup(17'd3, 2'd1, 8'd1, 1, "R4 refetch after flush");

    // R6: fill all eight lines, re-touch oldest, then force a replacement
    csrWrite(1'b0, 16'h0000);
    memGen   = 8'd2;
    reqStall = 2;
    for (int g = 16; g < 24; g++) doLookup(17'(g), 2'd0, 8'd2, 1, "R6 fill line");
    reqStall = 1;
    doLookup(17'd16, 2'd1, 8'd2, 0, "R6 oldest re-touched");
    doLookup(17'd24, 2'd0, 8'd2, 1, "R6 ninth group");
    doLookup(17'd16, 2'd2, 8'd2, 0, "R6 recently used kept");
    doLookup(17'd21, 2'd0, 8'd2, 0, "R6 other line kept");
    doLookup(17'd20, 2'd0, 8'd2, 1, "R6 pseudo-LRU victim evicted");

    // R5: selective invalidate of tag 20 (groups 40 and 41); group 42 has tag 21
    csrWrite(1'b0, 16'h0000);
    memGen = 8'd3;
    doLookup(17'd40, 2'd0, 8'd3, 1, "R5 setup 40");
    doLookup(17'd41, 2'd0, 8'd3, 1, "R5 setup 41");
    doLookup(17'd42, 2'd0, 8'd3, 1, "R5 setup 42");
    csrWrite(1'b1, 16'd20);
    memGen = 8'd4;
    doLookup(17'd42, 2'd1, 8'd3, 0, "R5 other tag kept");
    doLookup(17'd40, 2'd1, 8'd4, 1, "R5 matching group cleared");
    doLookup(17'd41, 2'd2, 8'd4, 1, "R5 second group same tag cleared");

    // R8: read after write completes with zero, after the flush
    csrWrite(1'b0, 16'h1234);
    csrRead("R8");
    memGen = 8'd5;
    doLookup(17'd42, 2'd0, 8'd5, 1, "R8 flush visible after read");

    // R7: matching invalidate during an outstanding fill
    memGen    = 8'd6;
    respDelay = 12;
    fork
      doLookup(17'd50, 2'd0, 8'd6, 2, "R7 killed fill refetched");
      begin
        repeat (5) @(negedge clk);
        csrWrite(1'b1, 16'd25);
      end
    join

    // R7: non-matching invalidate during an outstanding fill
    fork
      doLookup(17'd60, 2'd0, 8'd6, 1, "R7 unrelated invalidate");
      begin
        repeat (5) @(negedge clk);
        csrWrite(1'b1, 16'd99);
      end
    join
    respDelay = 2;
    doLookup(17'd60, 2'd3, 8'd6, 0, "R7 fill installed");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule